// File: doc/BRIEF.md
# Page Write Buffer and Program Sequencer

This block sits behind the serial command decoder of a small non-volatile memory. Once a memory-write instruction and its start address have been decoded, it gathers up to four data bytes into a page buffer. Only the two low address bits advance, so extra bytes wrap around the page and overwrite earlier slots. When chip select is released, the decoder reports the event together with the current bit count. If that release lands exactly on a byte boundary, after at least one whole data byte, and writing is permitted, the block starts a self-timed programming cycle. During that cycle it issues one memory write per loaded slot that lies outside the protected range, and it holds busy for a fixed number of clocks.

The same start rule applies to a status-register write. In that case the block collects a status data byte and commits its two protection-level bits through a separate strobe. At the end of every cycle a one-clock done pulse tells the surrounding logic to clear its write-enable latch. Serial decoding and status formatting are handled outside this block.

Top module: `pgwr_sequencer`

## Requirements
- R1: After reset, `busy`, `done`, `mem_we` and `stat_we` are all low.
- R2: A legal start makes `busy` high from the next clock for exactly `CYCLE_CLKS` clocks. `done` is then high for one clock, in the first clock after `busy` falls.
- R3: During a cycle, each loaded slot is written once, in slot order 0 to 3, within the first four busy clocks. Each write uses address {page, slot} and that slot's byte. Unloaded slots are never written, and no write happens outside `busy`.
- R4: The first data byte goes to slot `start_addr[1:0]`, and each further byte goes to the next slot modulo 4. The page (`start_addr[8:2]`) stays fixed, so a partial page may start mid-page.
- R5: With more than four data bytes, the slot index wraps, and a later byte replaces the earlier byte in the same slot.
- R6: If `cs_rise` arrives with `bit_cnt` not zero, the loaded data is discarded and no cycle starts.
- R7: If `cs_rise` arrives before any complete data byte, no cycle starts.
- R8: If `wr_allowed` is low when `cs_rise` arrives, the instruction is ignored and no cycle starts.
- R9: `prot_lvl` is latched at the start. The levels are: 0 protects nothing; 1 protects addresses whose two top bits are 11; 2 protects addresses whose top bit is 1; 3 protects everything. Slots in the protected range are not written, but the cycle still runs.
- R10: After `sr_start`, the last status byte received is committed by a single `stat_we` pulse in the first busy clock, with `stat_bp` = byte bits [3:2]. The start rules of R2, R6, R7 and R8 apply to it as well.
- R11: While `busy` is high, `wr_start`, `sr_start`, `byte_strobe` and `cs_rise` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start | input | 1 | Memory-write instruction with address decoded (pulse) |
| sr_start | input | 1 | Status-write instruction decoded (pulse) |
| start_addr | input | ADDR_W | Start byte address of the write |
| byte_strobe | input | 1 | A complete data byte is available (pulse) |
| byte_data | input | DATA_W | Data byte received |
| bit_cnt | input | BIT_W | Bits of the current byte shifted in so far |
| cs_rise | input | 1 | Chip-select release event (pulse) |
| wr_allowed | input | 1 | Write latch set and write-protect pin high |
| prot_lvl | input | 2 | Block protection level |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| stat_we | output | 1 | Status protection-bit write strobe |
| stat_bp | output | 2 | Protection bits to store |
| busy | output | 1 | Programming cycle in progress |
| done | output | 1 | One-clock end-of-cycle pulse |

## Verification
The bench sets `CYCLE_CLKS` to 12. With that value a whole cycle, including the four commit clocks, fits in a few dozen clocks, so every start and abort case can be run back to back. The address and data widths stay at their defaults of 9 and 8. This means the 4-byte page, the wrap within a page, and each protection level's boundary at 0x100 and 0x180 all fall within the 512-byte space used in the tests.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LD_MEM,
    ST_LD_SR,
    ST_COMMIT,
    ST_WAIT
  } pg_state_t;

  // Protection decision from the two top address bits and the level code.
  function automatic logic prot_hit(input logic [1:0] top2, input logic [1:0] lvl);
    case (lvl)
      2'd0:    prot_hit = 1'b0;
      2'd1:    prot_hit = (top2 == 2'b11);
      2'd2:    prot_hit = top2[1];
      default: prot_hit = 1'b1;
    endcase
  endfunction

  // Slot index advance, wrapping inside the page.
  function automatic logic [7:0] slot_next(input logic [7:0] s, input int unsigned n);
    slot_next = (32'(s) + 1 >= n) ? 8'd0 : s + 8'd1;
  endfunction

endpackage

// File: rtl/pgwr_buffer.sv
module pgwr_buffer #(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 4,
  localparam int SLOT_W    = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - SLOT_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  open,
  input  logic [ADDR_W-1:0]     base_addr,
  input  logic                  byte_we,
  input  logic [DATA_W-1:0]     byte_in,
  input  logic [SLOT_W-1:0]     rd_slot,
  output logic [DATA_W-1:0]     rd_data,
  output logic [PAGE_BYTES-1:0] vld_mask,
  output logic [PAGE_W-1:0]     page
);
  import pgwr_pkg::*;

  logic [SLOT_W-1:0]     ptr_q;
  logic [PAGE_W-1:0]     page_q;
  logic [PAGE_BYTES-1:0] vld_q;
  logic [DATA_W-1:0]     slot_q [PAGE_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      page_q <= '0;
    end else if (open) begin
      ptr_q  <= base_addr[SLOT_W-1:0];
      page_q <= base_addr[ADDR_W-1:SLOT_W];
    end else if (byte_we) begin
      ptr_q  <= SLOT_W'(slot_next(8'(ptr_q), PAGE_BYTES));
    end
  end

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[i]  <= 1'b0;
        slot_q[i] <= '0;
      end else if (open) begin
        vld_q[i]  <= 1'b0;
      end else if (byte_we && ptr_q == SLOT_W'(i)) begin
        vld_q[i]  <= 1'b1;
        slot_q[i] <= byte_in;
      end
    end
  end

  assign rd_data  = slot_q[rd_slot];
  assign vld_mask = vld_q;
  assign page     = page_q;

  AST_BYTE_MARKS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we && !open) |=> vld_q[$past(ptr_q)]); // R5
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we && !open) |=> $stable(page_q)); // R4

endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
  parameter int CYCLE_CLKS = 1000000,
  localparam int CNT_W     = $clog2(CYCLE_CLKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expire
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= CNT_W'(CYCLE_CLKS - 1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire = run_q && (cnt_q == '0);

  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q != '0 && !load) |=> (run_q && cnt_q == $past(cnt_q) - 1'b1)); // R2

endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl #(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 4,
  localparam int SLOT_W    = $clog2(PAGE_BYTES),
  localparam int BIT_W     = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic              sr_start,
  input  logic              byte_strobe,
  input  logic [DATA_W-1:0] byte_data,
  input  logic [BIT_W-1:0]  bit_cnt,
  input  logic              cs_rise,
  input  logic              wr_allowed,
  input  logic [1:0]        prot_lvl,
  input  logic              any_loaded,
  input  logic              tmr_expire,
  output logic              open_mem,
  output logic              buf_we,
  output logic              tmr_load,
  output logic              busy,
  output logic              done,
  output logic              commit_en,
  output logic [SLOT_W-1:0] slot,
  output logic              is_sr,
  output logic [1:0]        lvl_q,
  output logic [DATA_W-1:0] sr_byte
);
  import pgwr_pkg::*;

  pg_state_t         state_q, state_d;
  logic [SLOT_W-1:0] slot_q;
  logic              sr_got_q, is_sr_q, done_q;
  logic [DATA_W-1:0] sr_byte_q;
  logic [1:0]        lvl_r;
  logic              loading, have_data, on_boundary, go;

  assign loading     = (state_q == ST_LD_MEM) || (state_q == ST_LD_SR);
  assign have_data   = (state_q == ST_LD_MEM) ? any_loaded : sr_got_q;
  assign on_boundary = (bit_cnt == '0);
  assign go          = loading && cs_rise && on_boundary && have_data && wr_allowed;

  assign open_mem  = (state_q == ST_IDLE) && wr_start;
  assign buf_we    = (state_q == ST_LD_MEM) && byte_strobe && !cs_rise;
  assign tmr_load  = go;
  assign busy      = (state_q == ST_COMMIT) || (state_q == ST_WAIT);
  assign commit_en = (state_q == ST_COMMIT);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (wr_start)      state_d = ST_LD_MEM;
        else if (sr_start) state_d = ST_LD_SR;
      end
      ST_LD_MEM, ST_LD_SR: begin
        if (go)           state_d = ST_COMMIT;
        else if (cs_rise) state_d = ST_IDLE;
      end
      ST_COMMIT: begin
        if (tmr_expire)                          state_d = ST_IDLE;
        else if (slot_q == SLOT_W'(PAGE_BYTES-1)) state_d = ST_WAIT;
      end
      ST_WAIT:  if (tmr_expire) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      slot_q    <= '0;
      sr_got_q  <= 1'b0;
      is_sr_q   <= 1'b0;
      sr_byte_q <= '0;
      lvl_r     <= '0;
      done_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= busy && tmr_expire;
      if (state_q == ST_IDLE && sr_start && !wr_start) sr_got_q <= 1'b0;
      if (state_q == ST_LD_SR && byte_strobe && !cs_rise) begin
        sr_got_q  <= 1'b1;
        sr_byte_q <= byte_data;
      end
      if (go) begin
        slot_q  <= '0;
        is_sr_q <= (state_q == ST_LD_SR);
        lvl_r   <= prot_lvl;
      end else if (commit_en) begin
        slot_q  <= SLOT_W'(slot_next(8'(slot_q), PAGE_BYTES));
      end
    end
  end

  assign done    = done_q;
  assign slot    = slot_q;
  assign is_sr   = is_sr_q;
  assign lvl_q   = lvl_r;
  assign sr_byte = sr_byte_q;

  AST_MIDBYTE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (loading && cs_rise && !on_boundary) |=> (state_q == ST_IDLE)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tmr_expire) |=> busy); // R11

endmodule

// File: rtl/pgwr_sequencer.sv
module pgwr_sequencer #(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 4,
  parameter int CYCLE_CLKS = 1000000,
  localparam int SLOT_W    = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - SLOT_W,
  localparam int BIT_W     = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic              sr_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_strobe,
  input  logic [DATA_W-1:0] byte_data,
  input  logic [BIT_W-1:0]  bit_cnt,
  input  logic              cs_rise,
  input  logic              wr_allowed,
  input  logic [1:0]        prot_lvl,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              stat_we,
  output logic [1:0]        stat_bp,
  output logic              busy,
  output logic              done
);
  import pgwr_pkg::*;

  logic                  open_mem, buf_we, tmr_load, tmr_expire, commit_en, is_sr;
  logic [SLOT_W-1:0]     slot;
  logic [1:0]            lvl_q;
  logic [DATA_W-1:0]     sr_byte, rd_data;
  logic [PAGE_BYTES-1:0] vld_mask;
  logic [PAGE_W-1:0]     page;
  logic [ADDR_W-1:0]     slot_addr;
  logic                  slot_prot;

  pgwr_ctrl #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .sr_start(sr_start),
    .byte_strobe(byte_strobe), .byte_data(byte_data), .bit_cnt(bit_cnt),
    .cs_rise(cs_rise), .wr_allowed(wr_allowed), .prot_lvl(prot_lvl),
    .any_loaded(|vld_mask), .tmr_expire(tmr_expire), .open_mem(open_mem),
    .buf_we(buf_we), .tmr_load(tmr_load), .busy(busy), .done(done),
    .commit_en(commit_en), .slot(slot), .is_sr(is_sr), .lvl_q(lvl_q),
    .sr_byte(sr_byte)
  );

  pgwr_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .open(open_mem), .base_addr(start_addr),
    .byte_we(buf_we), .byte_in(byte_data), .rd_slot(slot), .rd_data(rd_data),
    .vld_mask(vld_mask), .page(page)
  );

  pgwr_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .expire(tmr_expire)
  );

  assign slot_addr = {page, slot};
  assign slot_prot = prot_hit(slot_addr[ADDR_W-1 -: 2], lvl_q);

  assign mem_we    = commit_en && !is_sr && vld_mask[slot] && !slot_prot;
  assign mem_addr  = slot_addr;
  assign mem_wdata = rd_data;
  assign stat_we   = commit_en && is_sr && (slot == '0);
  assign stat_bp   = sr_byte[3:2];

  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R3
  AST_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, stat_we})); // R10
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R2
  AST_FULL_PROT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (lvl_q != 2'd3)); // R9

endmodule

// File: tb/pgwr_sequencer_tb.sv
module pgwr_sequencer_tb;
  localparam int CYC = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_start = 0, sr_start = 0, byte_strobe = 0, cs_rise = 0;
  logic       wr_allowed = 1;
  logic [8:0] start_addr = '0;
  logic [7:0] byte_data = '0;
  logic [2:0] bit_cnt = '0;
  logic [1:0] prot_lvl = '0;
  logic       mem_we, stat_we, busy, done;
  logic [8:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [1:0] stat_bp;

  int tests = 0, fails = 0, done_cnt = 0, exp_done = 0, busy_run = 0;
  logic [16:0] exp_q [$];
  logic [1:0]  exp_st [$];

  always #5 clk = ~clk;

  pgwr_sequencer #(.CYCLE_CLKS(CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .sr_start(sr_start),
    .start_addr(start_addr), .byte_strobe(byte_strobe), .byte_data(byte_data),
    .bit_cnt(bit_cnt), .cs_rise(cs_rise), .wr_allowed(wr_allowed),
    .prot_lvl(prot_lvl), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .stat_we(stat_we), .stat_bp(stat_bp),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic bit tb_prot(input int a, input int lvl);
    if (lvl == 0) return 0;
    if (lvl == 1) return a >= 384;
    if (lvl == 2) return a >= 256;
    return 1;
  endfunction

  // Monitor: compares design writes against the scoreboard queues.
  always @(negedge clk) if (rst_n) begin
    if (mem_we) begin
      if (exp_q.size() == 0) chk(0, "R3 unexpected write", {mem_addr, mem_wdata}, 0);
      else begin
        logic [16:0] e;
        e = exp_q.pop_front();
        chk({mem_addr, mem_wdata} == e, "R3 write addr/data", {mem_addr, mem_wdata}, e);
      end
    end
    if (stat_we) begin
      if (exp_st.size() == 0) chk(0, "R10 unexpected status write", stat_bp, 0);
      else begin
        logic [1:0] s;
        s = exp_st.pop_front();
        chk(stat_bp == s, "R10 status bits", stat_bp, s);
      end
    end
    if (busy) busy_run++;
    if (done) begin
      chk(busy_run == CYC, "R2 busy length", busy_run, CYC);
      done_cnt++;
      busy_run = 0;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send_bytes(input logic [7:0] d [8], input int n);
    for (int k = 0; k < n; k++) begin
      byte_data = d[k]; byte_strobe = 1; bit_cnt = 0; tick();
      byte_strobe = 0;
    end
  endtask

  // Driver: issues a memory write and pushes the expected commits.
  task automatic do_write(input int addr, input logic [7:0] d [8], input int n,
                          input int bc, input bit allow, input int lvl, input bit wait_end);
    logic [7:0] slot_d [4];
    bit         slot_v [4];
    int         p;
    bit         starts;
    for (int s = 0; s < 4; s++) slot_v[s] = 0;
    p = addr % 4;
    for (int k = 0; k < n; k++) begin
      slot_d[p] = d[k]; slot_v[p] = 1; p = (p + 1) % 4;
    end
    starts = (n > 0) && (bc == 0) && allow;
    if (starts) begin
      exp_done++;
      for (int s = 0; s < 4; s++)
        if (slot_v[s] && !tb_prot((addr / 4) * 4 + s, lvl))
          exp_q.push_back({9'((addr / 4) * 4 + s), slot_d[s]});
    end
    start_addr = 9'(addr); wr_start = 1; tick(); wr_start = 0;
    send_bytes(d, n);
    bit_cnt = 3'(bc); wr_allowed = allow; prot_lvl = 2'(lvl); cs_rise = 1; tick();
    cs_rise = 0; bit_cnt = 0;
    if (wait_end) begin
      repeat (CYC + 6) tick();
      wr_allowed = 1; prot_lvl = 0;
    end
  endtask

  task automatic do_status(input logic [7:0] d [8], input int n, input int bc, input bit allow);
    if (n > 0 && bc == 0 && allow) begin
      exp_done++; exp_st.push_back(d[n-1][3:2]);
    end
    sr_start = 1; tick(); sr_start = 0;
    send_bytes(d, n);
    bit_cnt = 3'(bc); wr_allowed = allow; cs_rise = 1; tick();
    cs_rise = 0; bit_cnt = 0;
    repeat (CYC + 6) tick();
    wr_allowed = 1;
  endtask

  task automatic settle(input string req);
    chk(exp_q.size() == 0, {req, " pending writes"}, exp_q.size(), 0);
    chk(done_cnt == exp_done, {req, " done count"}, done_cnt, exp_done);
    chk(busy_run == 0 && !busy, {req, " busy idle"}, busy_run, 0);
  endtask

  bit finished = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d [8];
    d = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5, 8'hF6, 8'h17, 8'h28};
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    chk(!busy, "R1 busy", busy, 0);
    chk(!done, "R1 done", done, 0);
    chk(!mem_we, "R1 mem_we", mem_we, 0);
    chk(!stat_we, "R1 stat_we", stat_we, 0);
    rst_n = 1; tick();

    do_write('h045, d, 1, 0, 1, 0, 1); settle("R2 single byte");
    do_write('h1A0, d, 4, 0, 1, 0, 1); settle("R3 full page");
    do_write('h0D2, d, 3, 0, 1, 0, 1); settle("R4 mid-page start");
    do_write('h011, d, 6, 0, 1, 0, 1); settle("R5 wrap overwrite");
    do_write('h020, d, 2, 3, 1, 0, 1); settle("R6 mid-byte release");
    do_write('h024, d, 2, 7, 1, 0, 1); settle("R6 mid-byte release late");
    do_write('h030, d, 0, 0, 1, 0, 1); settle("R7 no data");
    do_write('h040, d, 3, 0, 0, 0, 1); settle("R8 not allowed");
    do_write('h17C, d, 4, 0, 1, 1, 1); settle("R9 level1 below");
    do_write('h180, d, 2, 0, 1, 1, 1); settle("R9 level1 above");
    do_write('h1FE, d, 2, 0, 1, 2, 1); settle("R9 level2 protected");
    do_write('h0FD, d, 3, 0, 1, 2, 1); settle("R9 level2 open");
    do_write('h004, d, 4, 0, 1, 3, 1); settle("R9 level3 all");

    d[0] = 8'h0C; do_status(d, 1, 0, 1); settle("R10 status write");
    d[0] = 8'h08; d[1] = 8'h04; do_status(d, 2, 0, 1); settle("R10 status last byte");
    do_status(d, 1, 5, 1); settle("R10 status mid-byte");
    do_status(d, 1, 0, 0); settle("R10 status not allowed");

    // R11: instruction sent while busy must have no effect
    d = '{8'h5A, 8'h6B, 8'h7C, 8'h8D, 8'h00, 8'h00, 8'h00, 8'h00};
    do_write('h100, d, 1, 0, 1, 0, 0);
    tick();
    chk(busy, "R11 busy running", busy, 1);
    start_addr = 9'h050; wr_start = 1; sr_start = 1; tick(); wr_start = 0; sr_start = 0;
    byte_data = 8'h99; byte_strobe = 1; tick(); byte_strobe = 0;
    cs_rise = 1; tick(); cs_rise = 0;
    repeat (CYC + 6) tick();
    settle("R11 ignored while busy");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule